// File: doc/BRIEF.md
# Four-State Event-Driven Trace Sequencer

This block keeps a two-bit sequencer position in the range 0 to 3 and moves it one step at a time. Each pair of neighbouring positions has its own transition-control register. That register holds two programmable event sources. The forward source moves the position from n up to n+1. The backward source moves it from n+1 back down to n. Each event source names either one of 32 single resource lines or one of 16 resource-pair results. The pair results are combined outside the block and arrive here as a vector.

Software sets up the three registers through a small write/read port while the trace unit is idle. Once the unit is running, the registers are frozen. The position then follows the resource inputs on every clock. Trace logic downstream uses the position output to make decisions that depend on a sequence of events.

The machine has four named states: SEQ_S0, SEQ_S1, SEQ_S2 and SEQ_S3. It has six named transitions: ADV01, ADV12, ADV23, RET10, RET21 and RET32. HOLD means no move.

Top module: `trace_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces the state to 0 and clears all three transition registers, so each one reads back 0.
- R2: Register layout, with addresses 0, 1 and 2 selecting registers 0, 1 and 2:
  - bits [4:0] forward select;
  - bit 7 forward type;
  - bits [12:8] backward select;
  - bit 15 backward type.
  All other bits read as zero, whatever was written to them. Address 3 reads zero. Read data is combinational from `addr`.
- R3: A write (`wr_en` high at an edge) updates the addressed register only while `idle` is 1. A write made while `idle` is 0 leaves every register unchanged.
- R4: In state n (n = 0, 1, 2), if the forward event of register n is true at an edge and the backward event of register n-1 is not true, the state becomes n+1 after that edge. This applies to ADV01, ADV12 and ADV23.
- R5: In state n+1, if the backward event of register n is true at an edge and the forward event of register n+1 is not true, the state becomes n after that edge. This applies to RET10, RET21 and RET32.
- R6: A type bit of 0 makes the event equal to `res_single[select]`. Single index 0 never fires, whatever `res_single[0]` is.
- R7: A type bit of 1 makes the event equal to `res_pair[select[3:0]]`, with select bit 4 ignored. Pair index 0 never fires, whatever `res_pair[0]` is.
- R8: Only the two events that belong to the current state are considered. The state changes by at most one step per clock.
- R9: If the forward and backward events for the current state are both true at an edge, the state holds (HOLD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle | input | 1 | 1 = trace unit idle (register writes accepted), 0 = running |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register index for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register at `addr` |
| res_single | input | 32 | Single resource lines |
| res_pair | input | 16 | Pre-combined resource-pair results |
| state | output | 2 | Current sequencer state |

## Verification
A state result is due at the first clock edge after the resources are applied. The bench therefore drives inputs just after a falling edge and compares the state at the next falling edge, once the rising edge in between has been taken. Readback is combinational, but it reflects a write only after the edge that takes the write. So reads are issued in the cycle after a write and compared at the following falling edge. Every expected item carries the falling-edge count at which it is due, and the monitor compares an item only at that count.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int SEQ_N_TRANS   = 3;
    localparam int SEQ_N_SINGLE  = 32;
    localparam int SEQ_N_PAIR    = 16;
    localparam int SEQ_SEL_W     = $clog2(SEQ_N_SINGLE);
    localparam int SEQ_PAIR_W    = $clog2(SEQ_N_PAIR);
    localparam int SEQ_DATA_W    = 32;
    localparam int SEQ_ADDR_W    = 2;

    // bit positions decoded by software
    localparam int SEQ_FSEL_LSB  = 0;
    localparam int SEQ_FTYPE_BIT = 7;
    localparam int SEQ_BSEL_LSB  = 8;
    localparam int SEQ_BTYPE_BIT = 15;

    typedef enum logic [1:0] {
        SEQ_S0 = 2'd0,
        SEQ_S1 = 2'd1,
        SEQ_S2 = 2'd2,
        SEQ_S3 = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic                 btype;
        logic [SEQ_SEL_W-1:0] bsel;
        logic                 ftype;
        logic [SEQ_SEL_W-1:0] fsel;
    } seq_cfg_t;

    localparam int SEQ_CFG_W = $bits(seq_cfg_t);

endpackage

// File: rtl/seq_evt_sel.sv
module seq_evt_sel
    import seq_pkg::*;
#(
    parameter int N_SINGLE = SEQ_N_SINGLE,
    parameter int N_PAIR   = SEQ_N_PAIR
) (
    input  logic                        typ,
    input  logic [$clog2(N_SINGLE)-1:0] sel,
    input  logic [N_SINGLE-1:0]         single,
    input  logic [N_PAIR-1:0]           pair,
    output logic                        fire
);
    localparam int PW = $clog2(N_PAIR);

    logic [PW-1:0] pidx;

    always_comb begin
        pidx = sel[PW-1:0];
        fire = 1'b0;
        if (typ) begin
            // pair 0 is not a valid source
            if (pidx != '0) fire = pair[pidx];
        end else begin
            // single 0 is tied false
            if (sel != '0) fire = single[sel];
        end
    end

endmodule

// File: rtl/seq_ctrl_regs.sv
module seq_ctrl_regs
    import seq_pkg::*;
#(
    parameter int N_TRANS = SEQ_N_TRANS,
    parameter int DATA_W  = SEQ_DATA_W,
    parameter int ADDR_W  = SEQ_ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       idle,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [N_TRANS*SEQ_CFG_W-1:0] cfg_flat
);
    seq_cfg_t cfg_q [N_TRANS];

    function automatic seq_cfg_t unpack_word(input logic [DATA_W-1:0] w);
        seq_cfg_t c;
        c.fsel  = w[SEQ_FSEL_LSB +: SEQ_SEL_W];
        c.ftype = w[SEQ_FTYPE_BIT];
        c.bsel  = w[SEQ_BSEL_LSB +: SEQ_SEL_W];
        c.btype = w[SEQ_BTYPE_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(input seq_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SEQ_FSEL_LSB +: SEQ_SEL_W] = c.fsel;
        w[SEQ_FTYPE_BIT]             = c.ftype;
        w[SEQ_BSEL_LSB +: SEQ_SEL_W] = c.bsel;
        w[SEQ_BTYPE_BIT]             = c.btype;
        return w;
    endfunction

    generate
        for (genvar i = 0; i < N_TRANS; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    cfg_q[i] <= '0;
                end else if (wr_en && idle && (addr == ADDR_W'(i))) begin
                    cfg_q[i] <= unpack_word(wdata);
                end
            end
            assign cfg_flat[i*SEQ_CFG_W +: SEQ_CFG_W] = cfg_q[i];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_TRANS; i++) begin
            if (addr == ADDR_W'(i)) rdata = pack_word(cfg_q[i]);
        end
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int N_TRANS = SEQ_N_TRANS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_TRANS-1:0] fwd_ev,
    input  logic [N_TRANS-1:0] bwd_ev,
    output logic [1:0]         state_o
);
    typedef enum logic [2:0] {
        TR_HOLD, TR_ADV01, TR_ADV12, TR_ADV23, TR_RET10, TR_RET21, TR_RET32
    } seq_tr_e;

    seq_state_e state_q, state_d;
    seq_tr_e    tr;

    // transition choice
    always_comb begin
        tr = TR_HOLD;
        unique case (state_q)
            SEQ_S0: if (fwd_ev[0]) tr = TR_ADV01;
            SEQ_S1: begin
                if (fwd_ev[1] && !bwd_ev[0])      tr = TR_ADV12;
                else if (bwd_ev[0] && !fwd_ev[1]) tr = TR_RET10;
            end
            SEQ_S2: begin
                if (fwd_ev[2] && !bwd_ev[1])      tr = TR_ADV23;
                else if (bwd_ev[1] && !fwd_ev[2]) tr = TR_RET21;
            end
            SEQ_S3: if (bwd_ev[2]) tr = TR_RET32;
            default: tr = TR_HOLD;
        endcase
    end

    always_comb begin
        unique case (tr)
            TR_ADV01: state_d = SEQ_S1;
            TR_ADV12: state_d = SEQ_S2;
            TR_ADV23: state_d = SEQ_S3;
            TR_RET10: state_d = SEQ_S0;
            TR_RET21: state_d = SEQ_S1;
            TR_RET32: state_d = SEQ_S2;
            default:  state_d = state_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_S0;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        state_o = state_q;
    end

endmodule

// File: rtl/trace_sequencer.sv
module trace_sequencer
    import seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        idle,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [31:0] res_single,
    input  logic [15:0] res_pair,
    output logic [1:0]  state
);
    logic [SEQ_N_TRANS*SEQ_CFG_W-1:0] cfg_flat;
    logic [SEQ_N_TRANS-1:0]           fwd_ev;
    logic [SEQ_N_TRANS-1:0]           bwd_ev;

    seq_ctrl_regs #(
        .N_TRANS (SEQ_N_TRANS),
        .DATA_W  (SEQ_DATA_W),
        .ADDR_W  (SEQ_ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .idle     (idle),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .cfg_flat (cfg_flat)
    );

    generate
        for (genvar n = 0; n < SEQ_N_TRANS; n++) begin : g_evt
            seq_cfg_t c;
            assign c = cfg_flat[n*SEQ_CFG_W +: SEQ_CFG_W];

            seq_evt_sel #(.N_SINGLE(SEQ_N_SINGLE), .N_PAIR(SEQ_N_PAIR)) u_fwd (
                .typ    (c.ftype),
                .sel    (c.fsel),
                .single (res_single),
                .pair   (res_pair),
                .fire   (fwd_ev[n])
            );

            seq_evt_sel #(.N_SINGLE(SEQ_N_SINGLE), .N_PAIR(SEQ_N_PAIR)) u_bwd (
                .typ    (c.btype),
                .sel    (c.bsel),
                .single (res_single),
                .pair   (res_pair),
                .fire   (bwd_ev[n])
            );
        end
    endgenerate

    seq_fsm #(.N_TRANS(SEQ_N_TRANS)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .fwd_ev  (fwd_ev),
        .bwd_ev  (bwd_ev),
        .state_o (state)
    );

endmodule

// File: rtl/seq_checker.sv
module seq_checker (
    input logic        clk,
    input logic        rst,
    input logic        idle,
    input logic [1:0]  state,
    input logic [2:0]  fwd_ev,
    input logic [2:0]  bwd_ev,
    input logic [35:0] cfg,
    input logic [31:0] rdata
);
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, state} == {1'b0, $past(state)}) ||
        ({1'b0, state} == {1'b0, $past(state)} + 3'd1) ||
        ({1'b0, state} + 3'd1 == {1'b0, $past(state)})); // R8

    AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !idle |=> (cfg == $past(cfg))); // R3

    AST_ADV_FROM0: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0 && fwd_ev[0]) |=> (state == 2'd1)); // R4

    AST_RET_FROM3: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd3 && bwd_ev[2]) |=> (state == 2'd2)); // R5

    AST_BOTH_HOLD1: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd1 && fwd_ev[1] && bwd_ev[0]) |=> (state == 2'd1)); // R9

    AST_BOTH_HOLD2: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2 && fwd_ev[2] && bwd_ev[1]) |=> (state == 2'd2)); // R9

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rdata[31:16] == 16'd0) && (rdata[14:13] == 2'd0) && (rdata[6:5] == 2'd0)); // R2

endmodule

bind trace_sequencer seq_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .idle   (idle),
    .state  (state),
    .fwd_ev (fwd_ev),
    .bwd_ev (bwd_ev),
    .cfg    (cfg_flat),
    .rdata  (rdata)
);

// File: tb/trace_sequencer_bench.sv
`timescale 1ns/1ps
module trace_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idle = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [31:0] res_single = 32'd0;
    logic [15:0] res_pair = 16'd0;
    logic [1:0]  state;

    always #5 clk = ~clk;

    trace_sequencer u_trace_sequencer (
        .clk(clk), .rst(rst), .idle(idle), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .res_single(res_single),
        .res_pair(res_pair), .state(state)
    );

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       tag;
        int          due;
    } item_t;

    item_t q[$];
    int ncount = 0;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // monitor: compare due items at each falling edge
    initial begin
        forever begin
            @(negedge clk);
            ncount++;
            while (q.size() > 0 && q[0].due == ncount) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_read ? rdata : {30'd0, state};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic push_state(input logic [1:0] e, input string tag);
        item_t it;
        it.is_read = 0; it.exp = {30'd0, e}; it.tag = tag; it.due = ncount + 1;
        q.push_back(it);
    endtask

    task automatic push_read(input logic [31:0] e, input string tag);
        item_t it;
        it.is_read = 1; it.exp = e; it.tag = tag; it.due = ncount + 1;
        q.push_back(it);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        tick(); wr_en = 1'b1; addr = a; wdata = d;
        tick(); wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
        tick(); wr_en = 1'b0; addr = a; push_read(e, tag);
    endtask

    task automatic step(input logic [31:0] s, input logic [15:0] p,
                        input logic [1:0] e, input string tag);
        tick(); res_single = s; res_pair = p; push_state(e, tag);
    endtask

    task automatic drain();
        tick(); tick();
    endtask

    initial begin
        tick(); rst = 1'b1;
        tick(); rst = 1'b1; push_state(2'd0, "R1 reset state");
        tick(); rst = 1'b0;
        read_reg(2'd0, 32'h0, "R1 reg0 cleared");
        read_reg(2'd1, 32'h0, "R1 reg1 cleared");
        read_reg(2'd2, 32'h0, "R1 reg2 cleared");

        // all resources high, registers zero: single 0 never fires
        step(32'hFFFF_FFFF, 16'hFFFF, 2'd0, "R6 single index 0 never fires");
        step(32'h0, 16'h0, 2'd0, "R6 idle inputs");

        // program: reg0 fwd single 5, bwd pair 3 (reserved bits set)
        write_reg(2'd0, 32'hFFFF_E365);
        read_reg(2'd0, 32'h0000_8305, "R2 reg0 layout and reserved zero");
        // reg1 fwd pair (sel 0x12 -> pair 2), bwd single 7
        write_reg(2'd1, 32'h0000_0792);
        read_reg(2'd1, 32'h0000_0792, "R2 reg1 readback");
        // reg2 fwd single 9, bwd pair 0
        write_reg(2'd2, 32'h0000_8009);
        read_reg(2'd2, 32'h0000_8009, "R2 reg2 readback");
        read_reg(2'd3, 32'h0, "R2 address 3 reads zero");

        // running: writes ignored
        tick(); idle = 1'b0;
        write_reg(2'd0, 32'h0000_1234);
        read_reg(2'd0, 32'h0000_8305, "R3 write while running ignored");

        step(32'h0000_0020, 16'h0, 2'd1, "R4 ADV01 via single 5");
        step(32'h0000_0020, 16'h0, 2'd1, "R8 stale forward event of reg0 ignored in S1");
        step(32'h0, 16'h000C, 2'd1, "R9 both events in S1 hold");
        step(32'h0, 16'h0008, 2'd0, "R5 RET10 via pair 3");
        step(32'h0000_0020, 16'h0, 2'd1, "R4 ADV01 again");
        step(32'h0, 16'h0004, 2'd2, "R7 ADV12 via pair 2 with select bit 4 ignored");
        step(32'h0000_0200, 16'h0, 2'd3, "R4 ADV23 via single 9");
        step(32'h0000_0200, 16'h0001, 2'd3, "R7 pair index 0 never fires");
        step(32'h0, 16'hFFFF, 2'd3, "R7 pair 0 source holds S3");

        // reprogram reg2 backward to single 10 while idle
        tick(); res_single = 32'h0; res_pair = 16'h0; idle = 1'b1;
        write_reg(2'd2, 32'h0000_0A09);
        read_reg(2'd2, 32'h0000_0A09, "R3 write accepted while idle");
        tick(); idle = 1'b0;
        step(32'h0000_0400, 16'h0, 2'd2, "R5 RET32 via single 10");
        step(32'h0000_0080, 16'h0, 2'd1, "R5 RET21 via single 7");
        step(32'h0000_0080, 16'h0, 2'd1, "R8 S1 ignores reg1 backward event");

        tick(); res_single = 32'h0; rst = 1'b1; push_state(2'd0, "R1 reset mid-run");
        tick(); rst = 1'b0;
        read_reg(2'd0, 32'h0, "R1 reg0 cleared after reset");
        drain();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule